// File: doc/BRIEF.md
# PHY Status Register with Latched Condition Bits

This block is one 16-bit read-only word in the management register space of a 10/100 Ethernet PHY. It collects condition flags from the link datapath into a single word that software can fetch in one access. Some bits show the present level of a signal. Others hold on to an event until software has seen it. Two bits latch low, so a brief loss of lock or of signal detect is never missed.

A bit that latches high is not cleared by reading this word. Each such bit is owned by another register address, and it is cleared by a read of that address. The block therefore watches the shared read strobe and address for every access, not only for accesses to its own word. Read data is registered. It appears on the cycle after the read strobe, and it reflects the state before any clearing caused by that same read.

Top module: `phy_status_reg`

## Requirements
- R1: A read at address 0x10 places the status word on `rd_data` in the cycle after the strobe. A read at any other address places 0 there. Bits 15 and 7 always read 0.
- R2: Bit 14 gives the value of `mdix_swapped` in the cycle of the read (1 = pairs swapped, 0 = normal).
- R3: Bit 13 sets on a `rx_err_evt` pulse. It stays set across reads of 0x10 and clears only on a read of 0x15.
- R4: Bit 12 sets on `polarity_inv`. It stays set across reads of 0x10 and 0x15, and clears only on a read of 0x1A.
- R5: Bit 11 sets on `false_carrier_evt` and clears only on a read of 0x14.
- R6: Bit 10 latches low on qualified signal detect. Qualified signal detect is `raw_sig_det & descr_lock` when `sd_qualify` is 1, and `raw_sig_det` alone when `sd_qualify` is 0.
- R7: Bit 9 latches low on `descr_lock`. After the input falls, the bit reads 0 until a read of 0x10. That read returns the held 0 and then reloads the bit from the present input level. While the level stays low, the bit stays 0.
- R8: Bit 8 sets on `page_rcvd` and clears only on a read of 0x06.
- R9: Bit 6 sets on `remote_fault_evt`. It clears on a read of 0x01 or on reset.
- R10: Bit 5 equals `jabber` while `link_10m` is 1, and reads 0 while `link_10m` is 0. Reads do not affect it.
- R11: When a setting event arrives in the same cycle as the clearing read of its bit, the bit stays set.
- R12: After reset, every latch-high bit is 0, and bits 10 and 9 follow their present input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe of the management register space |
| rd_addr | input | 5 | Register address of the read |
| rd_data | output | 16 | Registered read data |
| mdix_swapped | input | 1 | Present MDI/MDIX swap state |
| rx_err_evt | input | 1 | Receive error event pulse |
| false_carrier_evt | input | 1 | False carrier event pulse |
| polarity_inv | input | 1 | Inverted polarity detected |
| raw_sig_det | input | 1 | Raw signal detect level |
| descr_lock | input | 1 | Descrambler lock level |
| sd_qualify | input | 1 | Qualify signal detect with descrambler lock |
| page_rcvd | input | 1 | Link code word page received |
| remote_fault_evt | input | 1 | Remote fault indicated by link partner |
| jabber | input | 1 | Jabber condition level |
| link_10m | input | 1 | Link runs at 10 Mb/s |

## Verification
A clearing read and the condition that sets the same bit can fall in one cycle. The bench raises a receive error pulse in the same cycle as a read of 0x15. It then reads 0x10 and expects bit 13 to still be set. The second collision is a read of 0x10 while descrambler lock is still low. That read must return the held 0 and must leave the bit at 0, and the bit must return to 1 only after lock comes back and 0x10 is read again. Every expected word is pushed into a queue by the read driver, and the monitor compares each one with `rd_data` in the cycle after its strobe.

// File: rtl/phy_status_reg.sv
module phy_status_reg #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_STS   = 5'h10,
  parameter logic [AW-1:0] A_RXERR = 5'h15,
  parameter logic [AW-1:0] A_FCS   = 5'h14,
  parameter logic [AW-1:0] A_10BT  = 5'h1A,
  parameter logic [AW-1:0] A_ANER  = 5'h06,
  parameter logic [AW-1:0] A_BMSR  = 5'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  input  logic          mdix_swapped,
  input  logic          rx_err_evt,
  input  logic          false_carrier_evt,
  input  logic          polarity_inv,
  input  logic          raw_sig_det,
  input  logic          descr_lock,
  input  logic          sd_qualify,
  input  logic          page_rcvd,
  input  logic          remote_fault_evt,
  input  logic          jabber,
  input  logic          link_10m
);

  logic rxerr_q, fcs_q, pol_q, page_q, rf_q, sd_q, lock_q;

  wire rd_sts   = rd_en && rd_addr == A_STS;
  wire rd_rxerr = rd_en && rd_addr == A_RXERR;
  wire rd_fcs   = rd_en && rd_addr == A_FCS;
  wire rd_10bt  = rd_en && rd_addr == A_10BT;
  wire rd_aner  = rd_en && rd_addr == A_ANER;
  wire rd_bmsr  = rd_en && rd_addr == A_BMSR;

  wire sd_level = raw_sig_det & (descr_lock | ~sd_qualify);

  wire [15:0] word = {1'b0, mdix_swapped, rxerr_q, pol_q, fcs_q,
                      sd_q & sd_level, lock_q & descr_lock, page_q,
                      1'b0, rf_q, jabber & link_10m, 5'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxerr_q <= 1'b0;
      fcs_q   <= 1'b0;
      pol_q   <= 1'b0;
      page_q  <= 1'b0;
      rf_q    <= 1'b0;
      sd_q    <= 1'b1;
      lock_q  <= 1'b1;
      rd_data <= 16'h0;
    end else begin
      rxerr_q <= (rxerr_q & ~rd_rxerr) | rx_err_evt;
      fcs_q   <= (fcs_q   & ~rd_fcs)   | false_carrier_evt;
      pol_q   <= (pol_q   & ~rd_10bt)  | polarity_inv;
      page_q  <= (page_q  & ~rd_aner)  | page_rcvd;
      rf_q    <= (rf_q    & ~rd_bmsr)  | remote_fault_evt;
      sd_q    <= (sd_q   | rd_sts) & sd_level;
      lock_q  <= (lock_q | rd_sts) & descr_lock;
      if (rd_en) rd_data <= rd_sts ? word : 16'h0;
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] == 1'b0 && rd_data[7] == 1'b0);

  p_other_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != A_STS) |=> rd_data == 16'h0);

  p_mdix_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |=> rd_data[14] == $past(mdix_swapped));

  p_rxerr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxerr_q && !rd_rxerr) |=> rxerr_q);

  p_rxerr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxerr && !rx_err_evt) |=> !rxerr_q);

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxerr && rx_err_evt) |=> rxerr_q);

  p_lock_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !rd_sts) |=> !lock_q);

  p_lock_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !descr_lock |=> !lock_q);

  p_sd_unqualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_qualify && raw_sig_det && sd_q) |=> sd_q);

  p_jabber_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |=> rd_data[5] == $past(jabber && link_10m));

endmodule

// File: tb/phy_status_reg_tb.sv
module phy_status_reg_tb;
  logic clk = 0, rst_n = 0, rd_en = 0;
  logic [4:0] rd_addr = 0;
  logic [15:0] rd_data;
  logic mdix_swapped = 0, rx_err_evt = 0, false_carrier_evt = 0, polarity_inv = 0;
  logic raw_sig_det = 1, descr_lock = 1, sd_qualify = 1, page_rcvd = 0;
  logic remote_fault_evt = 0, jabber = 0, link_10m = 1;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  phy_status_reg u_dut (.clk, .rst_n, .rd_en, .rd_addr, .rd_data, .mdix_swapped,
    .rx_err_evt, .false_carrier_evt, .polarity_inv, .raw_sig_det, .descr_lock,
    .sd_qualify, .page_rcvd, .remote_fault_evt, .jabber, .link_10m);

  // called at a negedge, returns at the next negedge
  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : monitor
    bit f;
    item_t it;
    forever begin
      @(posedge clk); f = rd_en;
      @(negedge clk);
      if (f && q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (rd_data !== it.exp) begin
          fails++;
          $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    rd(5'h10, 16'h0600, "R12 reset state");
    rd(5'h05, 16'h0000, "R1 other address");
    mdix_swapped = 1; rd(5'h10, 16'h4600, "R2 mdix swapped");
    mdix_swapped = 0; rd(5'h10, 16'h0600, "R2 mdix normal");

    rx_err_evt = 1; idle(1); rx_err_evt = 0;
    rd(5'h10, 16'h2600, "R3 rx error set");
    rd(5'h10, 16'h2600, "R3 kept over status read");
    rd(5'h15, 16'h0000, "R3 clearing read");
    rd(5'h10, 16'h0600, "R3 cleared");

    false_carrier_evt = 1; idle(1); false_carrier_evt = 0;
    rd(5'h10, 16'h0E00, "R5 false carrier set");
    rd(5'h14, 16'h0000, "R5 clearing read");
    rd(5'h10, 16'h0600, "R5 cleared");

    polarity_inv = 1; idle(1); polarity_inv = 0;
    rd(5'h10, 16'h1600, "R4 polarity set");
    rd(5'h15, 16'h0000, "R4 wrong address read");
    rd(5'h10, 16'h1600, "R4 kept");
    rd(5'h1A, 16'h0000, "R4 clearing read");
    rd(5'h10, 16'h0600, "R4 cleared");

    page_rcvd = 1; idle(1); page_rcvd = 0;
    rd(5'h10, 16'h0700, "R8 page set");
    rd(5'h06, 16'h0000, "R8 clearing read");
    rd(5'h10, 16'h0600, "R8 cleared");

    remote_fault_evt = 1; idle(1); remote_fault_evt = 0;
    rd(5'h10, 16'h0640, "R9 remote fault set");
    rd(5'h01, 16'h0000, "R9 clearing read");
    rd(5'h10, 16'h0600, "R9 cleared by read");
    remote_fault_evt = 1; idle(1); remote_fault_evt = 0;
    rst_n = 0; idle(1); rst_n = 1; idle(1);
    rd(5'h10, 16'h0600, "R9 cleared by reset");

    jabber = 1; rd(5'h10, 16'h0620, "R10 jabber at 10M");
    link_10m = 0; rd(5'h10, 16'h0600, "R10 jabber masked at 100M");
    jabber = 0; link_10m = 1;

    descr_lock = 0; idle(1); descr_lock = 1; idle(1);
    rd(5'h10, 16'h0000, "R7 R6 lock drop held");
    rd(5'h10, 16'h0600, "R7 R6 reloaded");

    sd_qualify = 0;
    descr_lock = 0; idle(1); descr_lock = 1; idle(1);
    rd(5'h10, 16'h0400, "R6 unqualified sd unaffected");
    rd(5'h10, 16'h0600, "R7 reloaded");
    raw_sig_det = 0; idle(1); raw_sig_det = 1; idle(1);
    rd(5'h10, 16'h0200, "R6 raw sd drop");
    rd(5'h10, 16'h0600, "R6 reloaded");

    descr_lock = 0; idle(1);
    rd(5'h10, 16'h0400, "R7 low held");
    rd(5'h10, 16'h0400, "R7 clear to low level");
    descr_lock = 1; idle(1);
    rd(5'h10, 16'h0400, "R7 still held after recovery");
    rd(5'h10, 16'h0600, "R7 reloaded high");
    sd_qualify = 1;

    rx_err_evt = 1; rd(5'h15, 16'h0000, "R11 collide read");
    rx_err_evt = 0;
    rd(5'h10, 16'h2600, "R11 event wins over clear");
    rd(5'h15, 16'h0000, "R11 clear again");
    rd(5'h10, 16'h0600, "R11 cleared");

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule